// File: doc/BRIEF.md
# Interrupt Priority and Service Tracker

This block keeps the per-vector interrupt state of one processor: which vectors have been accepted and are waiting, which are being serviced, and whether each was accepted as a level or an edge interrupt. It offers the waiting vector with the highest number to the processor. It raises the request line only when that vector's 4-bit priority class (bits 7:4 of the vector) is strictly above the class of the current processor priority.

Software programs an 8-bit task priority threshold. From that threshold the block derives the processor priority, which gates delivery, and the arbitration priority, which a lowest-priority arbiter elsewhere can use. An acknowledge from the processor moves the offered vector from waiting to in service. An end-of-interrupt strobe retires the highest in-service vector. If that vector was accepted as a level interrupt, the block emits a one-cycle broadcast carrying the vector so that upstream level sources can re-arm.

The highest-vector searches are registered. Every output therefore follows an input strobe after at most two clock edges, and the request line stays low for the cycle in which the search results are stale.

Top module: `irq_svc_tracker`

## Requirements
- R1: After reset, irq_req, bcast_vld, ppr, apr and disp_vec are all zero, and no vector is waiting or in service.
- R2: An accept strobe whose vector is below 16 has no effect on any output or stored state.
- R3: disp_vec is the highest-numbered waiting vector, or 0 when none is waiting.
- R4: ppr equals the task priority when the task class (bits 7:4) is at least the class of the highest in-service vector. Otherwise ppr is {that class, 4'h0}. The highest in-service vector counts as 0 when none is in service.
- R5: apr equals the task priority when the task class is at least the class of disp_vec and strictly above the in-service class. Otherwise apr is {max(task class AND in-service class, disp_vec class), 4'h0}.
- R6: irq_req is high only when a vector is waiting and the class of disp_vec is strictly greater than ppr[7:4]. A task class of 15 therefore blocks every interrupt.
- R7: An ack strobe sampled while irq_req is high clears the waiting bit of disp_vec and sets its in-service bit. An ack sampled while irq_req is low has no effect.
- R8: An eoi strobe clears the highest in-service vector. If that vector's trigger bit is set, bcast_vld pulses high for exactly one cycle, one clock edge after the strobe, with bcast_vec equal to the vector. An eoi with nothing in service has no effect.
- R9: Each accept writes the vector's trigger bit: 1 when acc_level is high, 0 otherwise. A later edge accept of the same vector overrides an earlier level accept.
- R10: A waiting vector that is blocked by priority stays recorded and raises irq_req once the priority drops below its class.
- R11: irq_req is low in the cycle right after any accept, acknowledge or retire, and the outputs reflect the new state after the second clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_vld | input | 1 | Accept strobe for a new interrupt vector |
| acc_vec | input | 8 | Vector being accepted |
| acc_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| ack | input | 1 | Processor acknowledge strobe |
| eoi | input | 1 | End-of-interrupt strobe |
| tpr_we | input | 1 | Task priority write enable |
| tpr_wdata | input | 8 | Task priority value |
| disp_vec | output | 8 | Highest waiting vector (0 if none) |
| irq_req | output | 1 | Interrupt request to the processor |
| ppr | output | 8 | Processor priority |
| apr | output | 8 | Arbitration priority |
| bcast_vld | output | 1 | One-cycle pulse when a level vector is retired |
| bcast_vec | output | 8 | Vector carried by the broadcast |

## Verification
The trigger bit cannot be seen at any port. It only shows up as the presence or absence of a broadcast when a vector is finally retired. To reach that point the stimulus has to accept a vector, lower the task priority so the vector is delivered, acknowledge it and then retire it. The stimulus runs this chain once with a level accept and again after the same vector has been re-accepted as edge. A vector that was blocked while the priority was high is kept waiting through an acknowledge that must be ignored, and is then released by lowering the task priority.

// File: rtl/irq_trk_pkg.sv
package irq_trk_pkg;
  localparam int VEC_W    = 8;
  localparam int NUM_VEC  = 1 << VEC_W;
  localparam int CLS_W    = 4;
  localparam int RSVD_VEC = 16;

  typedef logic [VEC_W-1:0] vec_t;
  typedef logic [CLS_W-1:0] cls_t;

  function automatic cls_t cls_of(input vec_t v);
    return v[VEC_W-1 -: CLS_W];
  endfunction

  // Processor priority: threshold unless in-service class is higher.
  function automatic vec_t calc_ppr(input vec_t tpr, input vec_t isr_hi);
    if (cls_of(tpr) >= cls_of(isr_hi)) return tpr;
    return {cls_of(isr_hi), {(VEC_W-CLS_W){1'b0}}};
  endfunction

  // Arbitration priority.
  function automatic vec_t calc_apr(input vec_t tpr, input vec_t isr_hi, input vec_t irr_hi);
    cls_t a;
    if (cls_of(tpr) >= cls_of(irr_hi) && cls_of(tpr) > cls_of(isr_hi)) return tpr;
    a = cls_of(tpr) & cls_of(isr_hi);
    if (cls_of(irr_hi) > a) a = cls_of(irr_hi);
    return {a, {(VEC_W-CLS_W){1'b0}}};
  endfunction
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N = 256,
  parameter int W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] bits,
  output logic [W-1:0] idx_q,
  output logic         vld_q
);
  logic [W-1:0] idx_c;
  always_comb begin
    idx_c = '0;
    for (int i = 0; i < N; i++)
      if (bits[i]) idx_c = W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      vld_q <= 1'b0;
    end else begin
      idx_q <= idx_c;
      vld_q <= |bits;
    end
  end
endmodule

// File: rtl/irq_vec_state.sv
module irq_vec_state #(
  parameter int N = 256,
  parameter int W = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         acc_set,
  input  logic [W-1:0] acc_vec,
  input  logic         acc_level,
  input  logic         ack_set,
  input  logic [W-1:0] ack_vec,
  input  logic         eoi_clr,
  input  logic [W-1:0] eoi_vec,
  output logic [N-1:0] irr,
  output logic [N-1:0] isr,
  output logic [N-1:0] tmr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr <= '0;
      isr <= '0;
      tmr <= '0;
    end else begin
      if (ack_set) begin
        irr[ack_vec] <= 1'b0;
        isr[ack_vec] <= 1'b1;
      end
      if (eoi_clr) isr[eoi_vec] <= 1'b0;
      // accept last: a fresh request for the same vector survives an ack
      if (acc_set) begin
        irr[acc_vec] <= 1'b1;
        tmr[acc_vec] <= acc_level;
      end
    end
  end
endmodule

// File: rtl/irq_svc_tracker.sv
module irq_svc_tracker
  import irq_trk_pkg::*;
#(
  parameter int N = NUM_VEC,
  parameter int W = VEC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         acc_vld,
  input  logic [W-1:0] acc_vec,
  input  logic         acc_level,
  input  logic         ack,
  input  logic         eoi,
  input  logic         tpr_we,
  input  logic [W-1:0] tpr_wdata,
  output logic [W-1:0] disp_vec,
  output logic         irq_req,
  output logic [W-1:0] ppr,
  output logic [W-1:0] apr,
  output logic         bcast_vld,
  output logic [W-1:0] bcast_vec
);
  logic [N-1:0] irr, isr, tmr;
  logic [W-1:0] irr_hi, isr_hi, tpr_q;
  logic         irr_any, isr_any, fresh_q;
  logic         acc_ok, ack_fire, eoi_fire, state_chg;

  assign acc_ok    = acc_vld && (acc_vec >= W'(RSVD_VEC));
  assign ack_fire  = ack && irq_req;
  assign eoi_fire  = eoi && isr_any;
  assign state_chg = acc_ok || ack_fire || eoi_fire;

  irq_vec_state #(.N(N), .W(W)) u_state (
    .clk(clk), .rst_n(rst_n),
    .acc_set(acc_ok), .acc_vec(acc_vec), .acc_level(acc_level),
    .ack_set(ack_fire), .ack_vec(irr_hi),
    .eoi_clr(eoi_fire), .eoi_vec(isr_hi),
    .irr(irr), .isr(isr), .tmr(tmr)
  );

  irq_prio_enc #(.N(N), .W(W)) u_enc_irr (
    .clk(clk), .rst_n(rst_n), .bits(irr), .idx_q(irr_hi), .vld_q(irr_any)
  );
  irq_prio_enc #(.N(N), .W(W)) u_enc_isr (
    .clk(clk), .rst_n(rst_n), .bits(isr), .idx_q(isr_hi), .vld_q(isr_any)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tpr_q     <= '0;
      fresh_q   <= 1'b1;
      bcast_vld <= 1'b0;
      bcast_vec <= '0;
    end else begin
      if (tpr_we) tpr_q <= tpr_wdata;
      fresh_q   <= !state_chg;
      bcast_vld <= eoi_fire && tmr[isr_hi];
      if (eoi_fire && tmr[isr_hi]) bcast_vec <= isr_hi;
    end
  end

  assign disp_vec = irr_any ? irr_hi : '0;
  assign ppr      = calc_ppr(tpr_q, isr_any ? isr_hi : '0);
  assign apr      = calc_apr(tpr_q, isr_any ? isr_hi : '0, disp_vec);
  assign irq_req  = fresh_q && irr_any && (cls_of(disp_vec) > cls_of(ppr));
endmodule

// File: rtl/irq_svc_tracker_chk.sv
module irq_svc_tracker_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         irq_req,
  input logic [W-1:0] disp_vec,
  input logic [W-1:0] ppr,
  input logic [W-1:0] tpr_q,
  input logic         ack_fire,
  input logic         eoi,
  input logic         bcast_vld
);
  AST_REQ_ABOVE_PPR: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> disp_vec[W-1 -: 4] > ppr[W-1 -: 4]);                 // R6
  AST_CLASS15_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (tpr_q[W-1 -: 4] == 4'hF) |-> !irq_req);                          // R6
  AST_NO_RESERVED_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> disp_vec >= W'(16));                                   // R2
  AST_PPR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    ppr >= tpr_q);                                                     // R4
  AST_REQ_DROPS_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> !irq_req);                                            // R11
  AST_BCAST_FROM_EOI: assert property (@(posedge clk) disable iff (!rst_n)
    bcast_vld |-> $past(eoi));                                         // R8
endmodule

bind irq_svc_tracker irq_svc_tracker_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .disp_vec(disp_vec),
  .ppr(ppr), .tpr_q(tpr_q), .ack_fire(ack_fire), .eoi(eoi),
  .bcast_vld(bcast_vld)
);

// File: tb/sim_irq_svc_tracker.sv
`timescale 1ns/1ps
module sim_irq_svc_tracker;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_vld = 1'b0, acc_level = 1'b0, ack = 1'b0, eoi = 1'b0, tpr_we = 1'b0;
  logic [7:0] acc_vec = '0, tpr_wdata = '0;
  logic [7:0] disp_vec, ppr, apr, bcast_vec;
  logic       irq_req, bcast_vld;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [7:0] tpr_m = 8'h00;

  always #2.5 clk = ~clk;

  irq_svc_tracker u0 (
    .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_vec(acc_vec),
    .acc_level(acc_level), .ack(ack), .eoi(eoi), .tpr_we(tpr_we),
    .tpr_wdata(tpr_wdata), .disp_vec(disp_vec), .irq_req(irq_req),
    .ppr(ppr), .apr(apr), .bcast_vld(bcast_vld), .bcast_vec(bcast_vec)
  );

  // op: 0 accept, 1 ack, 2 eoi, 3 write task priority
  typedef struct packed {
    logic [1:0] op;
    logic [7:0] dat;
    logic       lvl;
    logic [7:0] x_disp;   // expected highest waiting (0 if none)
    logic [7:0] x_isr;    // expected highest in service (0 if none)
    logic       x_req;
    logic       x_bc;
  } row_t;

  localparam int NROW = 14;
  localparam row_t TBL [NROW] = '{
    '{2'd0, 8'h35, 1'b0, 8'h35, 8'h00, 1'b1, 1'b0},
    '{2'd0, 8'h62, 1'b1, 8'h62, 8'h00, 1'b1, 1'b0},
    '{2'd3, 8'h70, 1'b0, 8'h62, 8'h00, 1'b0, 1'b0},
    '{2'd3, 8'h20, 1'b0, 8'h62, 8'h00, 1'b1, 1'b0},
    '{2'd1, 8'h00, 1'b0, 8'h35, 8'h62, 1'b0, 1'b0},
    '{2'd2, 8'h00, 1'b0, 8'h35, 8'h00, 1'b1, 1'b1},
    '{2'd1, 8'h00, 1'b0, 8'h00, 8'h35, 1'b0, 1'b0},
    '{2'd2, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0},
    '{2'd0, 8'h0A, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0},
    '{2'd3, 8'hF5, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0},
    '{2'd0, 8'hFE, 1'b0, 8'hFE, 8'h00, 1'b0, 1'b0},
    '{2'd3, 8'h00, 1'b0, 8'hFE, 8'h00, 1'b1, 1'b0},
    '{2'd1, 8'h00, 1'b0, 8'h00, 8'hFE, 1'b0, 1'b0},
    '{2'd2, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0}
  };

  // Bench-side restatement of the priority rules (integer arithmetic).
  function automatic logic [7:0] m_ppr(input logic [7:0] t, input logic [7:0] s);
    int tc = t / 16, sc = s / 16;
    return (tc < sc) ? 8'(sc * 16) : t;
  endfunction
  function automatic logic [7:0] m_apr(input logic [7:0] t, input logic [7:0] s, input logic [7:0] r);
    int tc = t / 16, sc = s / 16, rc = r / 16, m;
    if (!(tc < rc) && tc > sc) return t;
    m = tc & sc;
    if (rc > m) m = rc;
    return 8'(m * 16);
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  logic bc_seen, req_early;
  logic [7:0] bc_v;

  task automatic do_op(input logic [1:0] op, input logic [7:0] dat, input logic lvl);
    case (op)
      2'd0: begin acc_vld = 1'b1; acc_vec = dat; acc_level = lvl; end
      2'd1: ack = 1'b1;
      2'd2: eoi = 1'b1;
      default: begin tpr_we = 1'b1; tpr_wdata = dat; tpr_m = dat; end
    endcase
    @(negedge clk);
    bc_seen = bcast_vld; bc_v = bcast_vec; req_early = irq_req;
    acc_vld = 1'b0; ack = 1'b0; eoi = 1'b0; tpr_we = 1'b0;
    @(negedge clk);
    if (bcast_vld) bc_seen = 1'b1;   // a pulse lasting past one cycle is wrong
    @(negedge clk);
  endtask

  task automatic chk_state(input string req, input logic [7:0] xd, input logic [7:0] xs, input logic xr);
    chk(req, "disp_vec", disp_vec, xd);
    chk(req, "irq_req", {7'b0, irq_req}, {7'b0, xr});
    chk("R4", "ppr", ppr, m_ppr(tpr_m, xs));
    chk("R5", "apr", apr, m_apr(tpr_m, xs, xd));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] prev_isr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "irq_req", {7'b0, irq_req}, 8'h00);
    chk("R1", "bcast_vld", {7'b0, bcast_vld}, 8'h00);
    chk("R1", "ppr", ppr, 8'h00);
    chk("R1", "apr", apr, 8'h00);
    chk("R1", "disp_vec", disp_vec, 8'h00);

    // Table walk: R3 R6 R7 R8 R10 and R2 (row with vector 0x0A)
    prev_isr = 8'h00;
    for (int i = 0; i < NROW; i++) begin
      do_op(TBL[i].op, TBL[i].dat, TBL[i].lvl);
      chk_state("R3/R6", TBL[i].x_disp, TBL[i].x_isr, TBL[i].x_req);
      chk("R8", "bcast seen", {7'b0, bc_seen}, {7'b0, TBL[i].x_bc});
      if (TBL[i].x_bc) chk("R8", "bcast_vec", bc_v, prev_isr);
      prev_isr = TBL[i].x_isr;
    end

    // R2: lowest reserved and lowest legal vector; R11 latency
    do_op(2'd0, 8'h0F, 1'b1);
    chk("R2", "disp_vec after 0x0F", disp_vec, 8'h00);
    do_op(2'd0, 8'h10, 1'b0);
    chk("R11", "irq_req one cycle after accept", {7'b0, req_early}, 8'h00);
    chk("R11", "irq_req after two edges", {7'b0, irq_req}, 8'h01);
    chk("R3", "disp_vec 0x10", disp_vec, 8'h10);
    do_op(2'd1, 8'h00, 1'b0);
    do_op(2'd2, 8'h00, 1'b0);
    chk("R8", "edge retire no bcast", {7'b0, bc_seen}, 8'h00);

    // R10 + R7: blocked level vector, ignored ack, then released
    do_op(2'd3, 8'h60, 1'b0);
    do_op(2'd0, 8'h50, 1'b1);
    chk("R10", "blocked irq_req", {7'b0, irq_req}, 8'h00);
    do_op(2'd1, 8'h00, 1'b0);
    chk("R7", "ack ignored, still waiting", disp_vec, 8'h50);
    chk("R7", "ack ignored, ppr", ppr, 8'h60);
    do_op(2'd3, 8'h00, 1'b0);
    chk("R10", "released irq_req", {7'b0, irq_req}, 8'h01);
    do_op(2'd1, 8'h00, 1'b0);
    chk("R7", "ppr after ack", ppr, 8'h50);
    do_op(2'd2, 8'h00, 1'b0);
    chk("R8", "level retire bcast", {7'b0, bc_seen}, 8'h01);
    chk("R8", "level retire vec", bc_v, 8'h50);

    // R9: level accept overridden by edge accept of the same vector
    do_op(2'd0, 8'h50, 1'b1);
    do_op(2'd0, 8'h50, 1'b0);
    do_op(2'd1, 8'h00, 1'b0);
    do_op(2'd2, 8'h00, 1'b0);
    chk("R9", "edge override no bcast", {7'b0, bc_seen}, 8'h00);
    chk("R9", "ppr back to task", ppr, 8'h00);

    // R8: eoi with nothing in service
    do_op(2'd2, 8'h00, 1'b0);
    chk("R8", "empty eoi no bcast", {7'b0, bc_seen}, 8'h00);
    chk("R8", "empty eoi ppr", ppr, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule